// File: doc/BRIEF.md
# Cartridge bank-switching register unit

This block holds the bank-select state of a game-cartridge memory mapper. It watches a CPU write bus, made of an address, a data byte and a write strobe. From that state it produces three things: the physical bank numbers for four 8 KB program windows at CPU 0x8000–0xFFFF, the bank numbers for eight 1 KB pattern windows at 0x0000–0x1FFF of the picture bus, and a nametable mirroring select. It also turns a CPU address and a pattern address into flat ROM addresses.

Bank data is loaded in two steps. A write to the index region stores a register number and arms the unit. The next write to the data region loads that bank register and disarms it. A separate mode register, written anywhere in 0x6000–0x7FFF, can replace the two switchable program windows with one 16 KB bank. The pattern windows take the bank registers in a fixed, non-sequential assignment. Bank numbers wrap modulo the ROM sizes, which are parameters.

Top module: `cart_bank_unit`

## Requirements
- R1: After reset, the program windows hold banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1. The pattern windows hold banks 0 to 7. mirror_horiz is 0.
- R2: A write with address bits 15:13 = 011 stores the data byte as the mode value. From then on, program windows 0 and 1 follow the mode and bank registers 4 and 5.
- R3: When mode bit 7 is 1, program windows 0 and 1 are (2·mode[4:0]) mod PRG_BANKS and (2·mode[4:0]+1) mod PRG_BANKS. When mode bit 7 is 0, they are register 4 and register 5, each mod PRG_BANKS.
- R4: A write with address bits 15:13 = 100 sets mirror_horiz to data bit 0.
- R5: A write with address bits 15:13 = 101 stores the index and arms the unit. The next write with address bits 15:13 = 110 loads bank register index[2:0] and disarms the unit, so a second data write has no effect.
- R6: A data-region write while the unit is not armed changes no output.
- R7: When the pattern mapping is live, windows 0 and 1 are reg0 with bit 0 cleared and with bit 0 set. Windows 2 and 3 are reg2 with bit 0 cleared and with bit 0 set. Windows 4, 5, 6 and 7 are registers 6, 1, 7 and 3. Every value is taken mod CHR_BANKS.
- R8: Writes with address bits 15:13 = 111, including the addresses 0xE002 and 0xE003, have no effect. Writes below 0x6000 have no effect either.
- R9: The reset program mapping stays until a mode write or a load of register 4 or 5. The reset pattern mapping stays until a load of register 0, 1, 2, 3, 6 or 7.
- R10: Program windows 2 and 3 always hold PRG_BANKS-2 and PRG_BANKS-1.
- R11: prg_rom_addr is the bank of window cpu_addr[14:13] times 8192, plus cpu_addr[12:0]. chr_rom_addr is the bank of window ppu_addr[12:10] times 1024, plus ppu_addr[9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU address to translate (0x8000–0xFFFF) |
| ppu_addr | input | 13 | Pattern address to translate |
| prg_bank | output | 4·clog2(PRG_BANKS) | Program window banks; window i sits at bits [i·W +: W] |
| chr_bank | output | 8·clog2(CHR_BANKS) | Pattern window banks; window i sits at bits [i·W +: W] |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| prg_rom_addr | output | clog2(PRG_BANKS)+13 | Program ROM address |
| chr_rom_addr | output | clog2(CHR_BANKS)+10 | Pattern ROM address |

## Verification
The embedded assertions check the arm/disarm handshake on every cycle. They also check that unarmed data writes and top-region writes leave the state untouched, that a mirroring write is captured, and that in 16 KB mode the two switchable windows stay paired. Only the bench's scenarios can show the bank values themselves: the scrambled pattern assignment, the modulo wrap over every mode byte, the reset mapping that persists until the right register is loaded, and the flat ROM addresses. The bench checks these against expected values computed arithmetically.

// File: rtl/cart_bank_unit.sv
module cart_bank_unit #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [15:0]                           wr_addr,
  input  logic [7:0]                            wr_data,
  input  logic [15:0]                           cpu_addr,
  input  logic [12:0]                           ppu_addr,
  output logic [4*$clog2(PRG_BANKS)-1:0]        prg_bank,
  output logic [8*$clog2(CHR_BANKS)-1:0]        chr_bank,
  output logic                                  mirror_horiz,
  output logic [$clog2(PRG_BANKS)+12:0]         prg_rom_addr,
  output logic [$clog2(CHR_BANKS)+9:0]          chr_rom_addr
);
  localparam int PB = $clog2(PRG_BANKS);
  localparam int CB = $clog2(CHR_BANKS);

  function automatic logic [PB-1:0] pwrap(input logic [7:0] v);
    logic [15:0] t;
    t = {8'd0, v} % 16'(PRG_BANKS);
    return t[PB-1:0];
  endfunction

  function automatic logic [CB-1:0] cwrap(input logic [7:0] v);
    logic [15:0] t;
    t = {8'd0, v} % 16'(CHR_BANKS);
    return t[CB-1:0];
  endfunction

  logic [7:0] mode, idx;
  logic [7:0] regs [8];
  logic       armed, prg_live, chr_live;

  wire [2:0] rgn     = wr_addr[15:13];
  wire       wr_mode = wr_en && rgn == 3'b011;
  wire       wr_mir  = wr_en && rgn == 3'b100;
  wire       wr_idx  = wr_en && rgn == 3'b101;
  wire       wr_dat  = wr_en && rgn == 3'b110;
  wire       wr_bank = wr_dat && armed;
  wire [2:0] sel     = idx[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      idx <= '0;
      armed <= 1'b0;
      mirror_horiz <= 1'b0;
      prg_live <= 1'b0;
      chr_live <= 1'b0;
      for (int i = 0; i < 8; i++) regs[i] <= '0;
    end else begin
      if (wr_mode) begin
        mode <= wr_data;
        prg_live <= 1'b1;
      end
      if (wr_mir) mirror_horiz <= wr_data[0];
      if (wr_idx) begin
        idx <= wr_data;
        armed <= 1'b1;
      end
      if (wr_bank) begin
        regs[sel] <= wr_data;
        armed <= 1'b0;
        if (sel == 3'd4 || sel == 3'd5) prg_live <= 1'b1;
        else chr_live <= 1'b1;
      end
    end
  end

  logic [PB-1:0] pw [4];
  logic [CB-1:0] cw [8];

  always_comb begin
    pw[2] = pwrap(8'(PRG_BANKS - 2));
    pw[3] = pwrap(8'(PRG_BANKS - 1));
    if (!prg_live) begin
      pw[0] = pwrap(8'd0);
      pw[1] = pwrap(8'd1);
    end else if (mode[7]) begin
      pw[0] = pwrap({2'b00, mode[4:0], 1'b0});
      pw[1] = pwrap({2'b00, mode[4:0], 1'b1});
    end else begin
      pw[0] = pwrap(regs[4]);
      pw[1] = pwrap(regs[5]);
    end
  end

  always_comb begin
    if (!chr_live) begin
      for (int i = 0; i < 8; i++) cw[i] = cwrap(8'(i));
    end else begin
      cw[0] = cwrap({regs[0][7:1], 1'b0});
      cw[1] = cwrap({regs[0][7:1], 1'b1});
      cw[2] = cwrap({regs[2][7:1], 1'b0});
      cw[3] = cwrap({regs[2][7:1], 1'b1});
      cw[4] = cwrap(regs[6]);
      cw[5] = cwrap(regs[1]);
      cw[6] = cwrap(regs[7]);
      cw[7] = cwrap(regs[3]);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_prg
    assign prg_bank[g*PB +: PB] = pw[g];
  end
  for (genvar g = 0; g < 8; g++) begin : g_chr
    assign chr_bank[g*CB +: CB] = cw[g];
  end

  assign prg_rom_addr = {pw[cpu_addr[14:13]], cpu_addr[12:0]};
  assign chr_rom_addr = {cw[ppu_addr[12:10]], ppu_addr[9:0]};

  // R5
  arm_on_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> armed);
  // R5
  disarm_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && armed) |=> !armed);
  // R6
  unarmed_data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !armed) |=> ($stable(prg_bank) && $stable(chr_bank) && !armed));
  // R8
  top_region_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rgn == 3'b111) |=> ($stable(prg_bank) && $stable(chr_bank)
      && $stable(mirror_horiz) && $stable(armed)));
  // R4
  mirror_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mir |=> mirror_horiz == $past(wr_data[0]));
  // R3
  pair_in_16k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_live && mode[7]) |-> (PB'(pw[0] + 1'b1) == pw[1] || PRG_BANKS != (1 << PB)));
endmodule

// File: tb/test_cart_bank_unit.sv
module test_cart_bank_unit;
  localparam int NP = 16;
  localparam int NC = 128;
  localparam int PB = $clog2(NP);
  localparam int CB = $clog2(NC);

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [15:0] wr_addr = 0, cpu_addr = 16'h8000;
  logic [7:0]  wr_data = 0;
  logic [12:0] ppu_addr = 0;
  logic [4*PB-1:0] prg_bank;
  logic [8*CB-1:0] chr_bank;
  logic mirror_horiz;
  logic [PB+12:0] prg_rom_addr;
  logic [CB+9:0]  chr_rom_addr;

  int checks = 0, errors = 0;

  cart_bank_unit #(.PRG_BANKS(NP), .CHR_BANKS(NC)) i_cart_bank_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .prg_bank(prg_bank), .chr_bank(chr_bank),
    .mirror_horiz(mirror_horiz), .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr));

  always #10 clk = ~clk;

  int m_mode = 0, m_idx = 0, m_mir = 0;
  int m_regs [8];
  bit m_arm = 0, m_plive = 0, m_clive = 0;

  function automatic int exp_prg(int w);
    if (w == 2) return NP - 2;
    if (w == 3) return NP - 1;
    if (!m_plive) return w;
    if (m_mode >= 128) return (2 * (m_mode % 32) + w) % NP;
    return m_regs[4 + w] % NP;
  endfunction

  function automatic int exp_chr(int w);
    int src [8] = '{0, 0, 2, 2, 6, 1, 7, 3};
    int v;
    if (!m_clive) return w;
    v = m_regs[src[w]];
    if (w < 4) v = (v / 2) * 2 + (w % 2);
    return v % NC;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int w = 0; w < 4; w++) cmp(tag, int'(prg_bank[w*PB +: PB]), exp_prg(w));
    for (int w = 0; w < 8; w++) cmp(tag, int'(chr_bank[w*CB +: CB]), exp_chr(w));
    cmp(tag, int'(mirror_horiz), m_mir);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 16'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
    case (a / 8192)
      3: begin m_mode = d; m_plive = 1; end
      4: m_mir = d % 2;
      5: begin m_idx = d; m_arm = 1; end
      6: if (m_arm) begin
           m_regs[m_idx % 8] = d; m_arm = 0;
           if (m_idx % 8 == 4 || m_idx % 8 == 5) m_plive = 1; else m_clive = 1;
         end
      default: ;
    endcase
  endtask

  task automatic load(int r, int d);
    wr(16'hA000 + r * 8, r);
    wr(16'hC000 + d, d);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset state");
    check_all("R10 fixed windows");

    load(3, 200);
    check_all("R9 pattern live, program still reset");
    load(4, 9);
    check_all("R9 program live after reg4");

    wr(16'hC000, 77);
    check_all("R6 unarmed data write");
    wr(16'hE002, 5); wr(16'hE003, 6); wr(16'hE000, 1); wr(16'hFFFF, 2);
    wr(16'h0000, 3); wr(16'h5FFF, 4);
    check_all("R8 ignored regions");

    for (int r = 0; r < 8; r++) begin
      int vals [6] = '{0, 1, 8'h55, 8'hAA, 8'hFF, 37};
      for (int k = 0; k < 6; k++) begin
        load(r, (vals[k] + r * 13) % 256);
        check_all("R7 pattern mapping / R5 load");
      end
      wr(16'hC000, 99);
      check_all("R5 second data write ignored");
    end

    for (int d = 0; d < 4; d++) begin
      wr(16'h8000 + d, d);
      check_all("R4 mirroring");
    end

    for (int m = 0; m < 256; m++) begin
      wr(16'h6000 + m, m);
      check_all("R2 R3 R11 mode sweep");
    end

    wr(16'h7FFF, 8'h85);
    for (int a = 0; a < 8; a++) begin
      cpu_addr = 16'(16'h8000 + a * 16'h1000 + a * 3);
      ppu_addr = 13'(a * 1024 + a * 5);
      #1;
      cmp("R11 prg address", int'(prg_rom_addr),
          exp_prg((a * 4096) / 8192) * 8192 + (a * 4096 + a * 3) % 8192);
      cmp("R11 chr address", int'(chr_rom_addr), exp_chr(a) * 1024 + a * 5);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule